// File: doc/BRIEF.md
# Track Trigger Decision Unit

This unit sits at the end of a track trigger pipeline. Once per event frame it takes the fitted results of a set of parallel track engines. Each engine sends one strobe and one track record per frame. Each valid track is tested against two programmable cuts. The first cut is on the magnitude of the longitudinal vertex position z0. The second is on the magnitude of inverse transverse momentum, so a small 1/pT means a high pT. The pass flags are gathered per azimuthal sixteenth.

At each output slot a small decision word is formed from those flags. There are two slots per frame, so the word goes out at twice the frame rate. A selectable grouping mode decides which region and which cut feeds each decision bit. Thresholds and the mode are written through a simple write port. They take effect only at frame boundaries, so a frame is never judged under mixed settings.

Top module: `trk_decision_unit`

## Requirements
- R1: After reset, `dec_word` and `dec_strobe` are 0. The z0 limit starts at 200 (20 cm with a 1 mm LSB), the inverse-pT limit starts at 256, and the grouping mode starts at 0.
- R2: The bits of the 57-bit record, counted from the LSB, are:
  - [11:0] z0, two's complement
  - [19:12] z0 error
  - [31:20] 1/pT, two's complement
  - [43:32] tan(lambda)
  - [53:44] superlayer hit map
  - [55:54] region tag
  - [56] track-valid flag

  Engine e occupies bits e*57 upward of `eng_rec`. A track passes the z cut when |z0| < limit. It passes the momentum cut when |1/pT| < inverse limit. A value equal to its limit fails. The value -2048 has magnitude 2048.
- R3: A record whose engine strobe is low, or whose valid flag is 0, adds nothing to any decision.
- R4: The region tag selects one of four sixteenths, 0 to 3. Eighth A is sixteenths 0 and 1; eighth B is sixteenths 2 and 3. In mode 0:
  - bit0 is set when a track in sixteenth 0 passes both cuts.
  - bit1 is the same for sixteenth 1.
  - bits 3:2 are 0.
- R5: In mode 1:
  - bit0 is set when any track in eighth A passes the z cut.
  - bit1 is set when any track in eighth A passes the momentum cut.
  - bit2 and bit3 are the same two tests for eighth B.
- R6: In mode 2:
  - bit0 is set when a track in eighth A passes both cuts.
  - bit1 is the same for eighth B.
  - bit2 is set when a track in sixteenth 0 passes both cuts.
  - bit3 is the same for sixteenth 1.
- R7: Mode 3 gives a word of all zeros. Bits 5:4 are 0 in every mode.
- R8: A frame is 16 cycles long and an output slot occurs every 8 cycles. `dec_strobe` is high for exactly one cycle per slot. The first pulse is in the 9th cycle after reset release, and a pulse follows every 8 cycles after that.
- R9: The word is loaded at the first slot after every engine has strobed at least once. Strobes from earlier, unfinished frames are kept and count towards this. The loaded word is held unchanged through later slots until the next complete set of strobes.
- R10: A write with `cfg_sel` set to:
  - 0 sets the z0 limit.
  - 1 sets the inverse-pT limit.
  - 2 sets the mode (low 2 bits).
  - 3 is ignored.

  A write becomes active only at the end of the current 16-cycle frame. Tracks and the word of the frame in which the write was made use the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eng_stb | input | 12 | One strobe per engine; its record is valid in the same cycle |
| eng_rec | input | 684 | Twelve packed 57-bit track records |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | Configuration target |
| cfg_wdata | input | 16 | Configuration write value |
| dec_word | output | 6 | Registered trigger decision word |
| dec_strobe | output | 1 | One-cycle pulse marking each output slot |

## Verification
The bench drives tracks whose z0 and 1/pT sit exactly on, one below, and far beyond each limit, including the most negative code. A design that compared with <=, or that took the magnitude wrongly, would raise a decision bit for a track at the limit or for the -2048 code. It rewrites thresholds and the mode halfway through a frame and checks that the frame is still judged by the old settings; an unshadowed design would change that frame's word early. It leaves one engine silent for a frame and later sends only that engine. A design that latched without a full set, or that discarded the partial set, would change the word too early or lose the earlier tracks. Every mode is swept under pseudo-random track sets.

// File: rtl/trkdec_pkg.sv
package trkdec_pkg;
  localparam int Z_W   = 12;
  localparam int ZE_W  = 8;
  localparam int IPT_W = 12;
  localparam int TL_W  = 12;
  localparam int HM_W  = 10;
  localparam int RG_W  = 2;
  localparam int N_SIX = 1 << RG_W;
  localparam int HALF  = N_SIX / 2;

  typedef struct packed {
    logic              ok;
    logic [RG_W-1:0]   rgn;
    logic [HM_W-1:0]   hmap;
    logic [TL_W-1:0]   tanl;
    logic [IPT_W-1:0]  ipt;
    logic [ZE_W-1:0]   zerr;
    logic [Z_W-1:0]    z0;
  } trk_rec_t;

  localparam int REC_W = $bits(trk_rec_t);

  typedef enum logic [1:0] {
    MODE_SIX2   = 2'd0,
    MODE_EIGHT4 = 2'd1,
    MODE_MIXED  = 2'd2,
    MODE_OFF    = 2'd3
  } dec_mode_t;

  typedef struct packed {
    logic [N_SIX-1:0] zc;
    logic [N_SIX-1:0] pc;
    logic [N_SIX-1:0] both;
  } rgn_flags_t;
endpackage

// File: rtl/trkdec_timer.sv
module trkdec_timer #(
  parameter int FRAME_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic slot_tick,
  output logic frame_tick
);
  localparam int SLOT_LEN = FRAME_LEN / 2;
  localparam int PH_W     = $clog2(FRAME_LEN);

  logic [PH_W-1:0] phase_q, phase_n;

  always_comb begin
    frame_tick = (phase_q == PH_W'(FRAME_LEN - 1));
    slot_tick  = frame_tick || (phase_q == PH_W'(SLOT_LEN - 1));
    phase_n    = frame_tick ? '0 : phase_q + PH_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_n;
  end

  assert_slot_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    slot_tick |=> !slot_tick)
    else $error("slot ticks on consecutive cycles");
endmodule

// File: rtl/trkdec_cfg.sv
module trkdec_cfg import trkdec_pkg::*; #(
  parameter int              CFG_W      = 16,
  parameter logic [Z_W-1:0]  ZLIM_RST   = Z_W'(200),
  parameter logic [IPT_W-1:0] PLIM_RST  = IPT_W'(256)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [CFG_W-1:0]  wdata,
  input  logic              frame_tick,
  output logic [Z_W-1:0]    act_zlim,
  output logic [IPT_W-1:0]  act_plim,
  output dec_mode_t         act_mode
);
  logic [Z_W-1:0]   shd_zlim_q, shd_zlim_n, act_zlim_n;
  logic [IPT_W-1:0] shd_plim_q, shd_plim_n, act_plim_n;
  dec_mode_t        shd_mode_q, shd_mode_n, act_mode_n;
  logic             unused_wdata;

  assign unused_wdata = ^wdata;

  always_comb begin
    shd_zlim_n = shd_zlim_q;
    shd_plim_n = shd_plim_q;
    shd_mode_n = shd_mode_q;
    if (we) begin
      case (sel)
        2'd0:    shd_zlim_n = wdata[Z_W-1:0];
        2'd1:    shd_plim_n = wdata[IPT_W-1:0];
        2'd2:    shd_mode_n = dec_mode_t'(wdata[1:0]);
        default: ;
      endcase
    end
    act_zlim_n = frame_tick ? shd_zlim_q : act_zlim;
    act_plim_n = frame_tick ? shd_plim_q : act_plim;
    act_mode_n = frame_tick ? shd_mode_q : act_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_zlim_q <= ZLIM_RST;
      shd_plim_q <= PLIM_RST;
      shd_mode_q <= MODE_SIX2;
      act_zlim   <= ZLIM_RST;
      act_plim   <= PLIM_RST;
      act_mode   <= MODE_SIX2;
    end else begin
      shd_zlim_q <= shd_zlim_n;
      shd_plim_q <= shd_plim_n;
      shd_mode_q <= shd_mode_n;
      act_zlim   <= act_zlim_n;
      act_plim   <= act_plim_n;
      act_mode   <= act_mode_n;
    end
  end

  assert_cfg_at_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(act_zlim) || !$stable(act_plim) || !$stable(act_mode)) |-> $past(frame_tick))
    else $error("active configuration changed away from a frame boundary");
endmodule

// File: rtl/trkdec_cut.sv
module trkdec_cut import trkdec_pkg::*; (
  input  logic             stb,
  input  trk_rec_t         rec,
  input  logic [Z_W-1:0]   zlim,
  input  logic [IPT_W-1:0] plim,
  output rgn_flags_t       flags
);
  logic [Z_W-1:0]   zmag;
  logic [IPT_W-1:0] pmag;
  logic             take, zpass, ppass;
  logic [N_SIX-1:0] hot;
  logic             unused_fields;

  assign unused_fields = ^{rec.hmap, rec.tanl, rec.zerr};

  always_comb begin
    zmag  = rec.z0[Z_W-1]   ? (~rec.z0  + Z_W'(1))   : rec.z0;
    pmag  = rec.ipt[IPT_W-1] ? (~rec.ipt + IPT_W'(1)) : rec.ipt;
    zpass = (zmag < zlim);
    ppass = (pmag < plim);
    take  = stb & rec.ok;
    hot   = '0;
    hot[rec.rgn] = take;
    flags.zc   = zpass ? hot : '0;
    flags.pc   = ppass ? hot : '0;
    flags.both = (zpass && ppass) ? hot : '0;
  end
endmodule

// File: rtl/trkdec_map.sv
module trkdec_map import trkdec_pkg::*; #(
  parameter int DEC_W = 6
) (
  input  rgn_flags_t       flags,
  input  dec_mode_t        mode,
  output logic [DEC_W-1:0] word
);
  always_comb begin
    word = '0;
    case (mode)
      MODE_SIX2: begin
        word[0] = flags.both[0];
        word[1] = flags.both[1];
      end
      MODE_EIGHT4: begin
        word[0] = |flags.zc[HALF-1:0];
        word[1] = |flags.pc[HALF-1:0];
        word[2] = |flags.zc[N_SIX-1:HALF];
        word[3] = |flags.pc[N_SIX-1:HALF];
      end
      MODE_MIXED: begin
        word[0] = |flags.both[HALF-1:0];
        word[1] = |flags.both[N_SIX-1:HALF];
        word[2] = flags.both[0];
        word[3] = flags.both[1];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/trk_decision_unit.sv
module trk_decision_unit import trkdec_pkg::*; #(
  parameter int               N_ENG     = 12,
  parameter int               FRAME_LEN = 16,
  parameter int               CFG_W     = 16,
  parameter int               DEC_W     = 6,
  parameter logic [Z_W-1:0]   ZLIM_RST  = Z_W'(200),
  parameter logic [IPT_W-1:0] PLIM_RST  = IPT_W'(256)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_ENG-1:0]       eng_stb,
  input  logic [N_ENG*REC_W-1:0] eng_rec,
  input  logic                   cfg_we,
  input  logic [1:0]             cfg_sel,
  input  logic [CFG_W-1:0]       cfg_wdata,
  output logic [DEC_W-1:0]       dec_word,
  output logic                   dec_strobe
);
  logic             slot_tick, frame_tick, latch;
  logic [Z_W-1:0]   act_zlim;
  logic [IPT_W-1:0] act_plim;
  dec_mode_t        act_mode;
  rgn_flags_t       eng_flags [N_ENG];
  rgn_flags_t       new_flags, acc_q, acc_n;
  logic [N_ENG-1:0] seen_q, seen_n;
  logic [DEC_W-1:0] map_word, word_n;

  trkdec_timer #(.FRAME_LEN(FRAME_LEN)) u_tmr (
    .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .frame_tick(frame_tick)
  );

  trkdec_cfg #(.CFG_W(CFG_W), .ZLIM_RST(ZLIM_RST), .PLIM_RST(PLIM_RST)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .frame_tick(frame_tick), .act_zlim(act_zlim), .act_plim(act_plim), .act_mode(act_mode)
  );

  for (genvar e = 0; e < N_ENG; e++) begin : g_eng
    trk_rec_t rec_e;
    assign rec_e = eng_rec[e*REC_W +: REC_W];
    trkdec_cut u_cut (
      .stb(eng_stb[e]), .rec(rec_e), .zlim(act_zlim), .plim(act_plim), .flags(eng_flags[e])
    );
  end

  trkdec_map #(.DEC_W(DEC_W)) u_map (.flags(acc_q), .mode(act_mode), .word(map_word));

  always_comb begin
    new_flags = '0;
    for (int e = 0; e < N_ENG; e++) new_flags = new_flags | eng_flags[e];
    latch  = slot_tick && (&seen_q);
    acc_n  = latch ? new_flags : (acc_q | new_flags);
    seen_n = latch ? eng_stb   : (seen_q | eng_stb);
    word_n = latch ? map_word  : dec_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q      <= '0;
      seen_q     <= '0;
      dec_word   <= '0;
      dec_strobe <= 1'b0;
    end else begin
      acc_q      <= acc_n;
      seen_q     <= seen_n;
      dec_word   <= word_n;
      dec_strobe <= slot_tick;
    end
  end

  assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_word[DEC_W-1:4] == '0)
    else $error("reserved decision bits driven");

  assert_off_mode_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (latch && act_mode == MODE_OFF) |=> dec_word == '0)
    else $error("disabled mode produced a decision");

  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_strobe |=> !dec_strobe)
    else $error("strobe longer than one cycle");

  assert_word_moves_at_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dec_word) |-> dec_strobe)
    else $error("decision word changed outside a slot");

  assert_hold_until_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_tick && !(&seen_q)) |=> $stable(dec_word))
    else $error("word loaded before all engines reported");
endmodule

// File: tb/trk_decision_unit_tb_top.sv
module trk_decision_unit_tb_top;
  import trkdec_pkg::*;
  localparam int N = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [N-1:0]     eng_stb = '0;
  logic [N*REC_W-1:0] eng_rec = '0;
  logic             cfg_we = 1'b0;
  logic [1:0]       cfg_sel = '0;
  logic [15:0]      cfg_wdata = '0;
  logic [5:0]       dec_word;
  logic             dec_strobe;

  always #4 clk = ~clk;

  trk_decision_unit dut_i (
    .clk(clk), .rst_n(rst_n), .eng_stb(eng_stb), .eng_rec(eng_rec),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .dec_word(dec_word), .dec_strobe(dec_strobe)
  );

  int nchk = 0, nfail = 0;
  int ph = 0;
  int tz[N], tp[N], trg[N];
  bit tok[N];
  int zlim = 200, plim = 256, mode = 0;
  bit [3:0] az = '0, ap = '0, ab = '0;
  bit [N-1:0] seen = '0;
  bit [5:0] last_word = '0;
  int lcg = 32'h1234_5678;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) ph <= 0; else ph <= (ph + 1) % 16;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int rnd(input int range);
    lcg = lcg * 1103515245 + 12345;
    return ((lcg >> 16) & 32'h7fff) % range;
  endfunction

  function automatic bit [5:0] exp_word();
    bit [5:0] w = '0;
    case (mode)
      0: begin w[0] = ab[0]; w[1] = ab[1]; end
      1: begin w[0] = |az[1:0]; w[1] = |ap[1:0]; w[2] = |az[3:2]; w[3] = |ap[3:2]; end
      2: begin w[0] = |ab[1:0]; w[1] = |ab[3:2]; w[2] = ab[0]; w[3] = ab[1]; end
      default: w = '0;
    endcase
    return w;
  endfunction

  task automatic wait_ph(input int n);
    while (ph != n) @(negedge clk);
  endtask

  task automatic drive(input bit [N-1:0] m);
    for (int e = 0; e < N; e++) begin
      eng_rec[e*REC_W +: REC_W] = {tok[e], 2'(trg[e]), 10'h3ff, 12'h0,
                                   12'(tp[e]), 8'h0, 12'(tz[e])};
      if (m[e] && tok[e]) begin
        bit zp = iabs(tz[e]) < zlim;
        bit pp = iabs(tp[e]) < plim;
        if (zp) az[trg[e]] = 1'b1;
        if (pp) ap[trg[e]] = 1'b1;
        if (zp && pp) ab[trg[e]] = 1'b1;
      end
    end
    seen |= m;
    eng_stb = m;
    @(negedge clk);
    eng_stb = '0;
  endtask

  task automatic frame(input string req, input bit [N-1:0] m1, input bit [N-1:0] m2,
                       input bit do_cfg, input int csel, input int cval);
    bit [5:0] exp;
    bit complete;
    wait_ph(1);
    drive(m1);
    drive(m2);
    if (do_cfg) begin
      cfg_we = 1'b1; cfg_sel = 2'(csel); cfg_wdata = 16'(cval);
      @(negedge clk);
      cfg_we = 1'b0;
    end
    complete = &seen;
    exp = complete ? exp_word() : last_word;
    wait_ph(8);
    chk({req, " slot word"}, 32'(dec_word), 32'(exp));
    chk("R8 strobe at slot", 32'(dec_strobe), 32'd1);
    @(negedge clk);
    chk("R8 strobe one cycle", 32'(dec_strobe), 32'd0);
    wait_ph(0);
    chk("R9 repeated word", 32'(dec_word), 32'(exp));
    chk("R8 strobe second slot", 32'(dec_strobe), 32'd1);
    last_word = exp;
    if (complete) begin az = '0; ap = '0; ab = '0; seen = '0; end
    if (do_cfg) begin
      if (csel == 0) zlim = cval;
      else if (csel == 1) plim = cval;
      else if (csel == 2) mode = cval & 3;
    end
  endtask

  task automatic clear_tracks();
    for (int e = 0; e < N; e++) begin tok[e] = 0; tz[e] = 0; tp[e] = 0; trg[e] = 0; end
  endtask

  task automatic rand_tracks();
    for (int e = 0; e < N; e++) begin
      tok[e] = (rnd(4) != 0);
      trg[e] = rnd(4);
      tz[e]  = rnd(601) - 300;
      tp[e]  = rnd(801) - 400;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    clear_tracks();
    repeat (3) @(negedge clk);
    chk("R1 reset word", 32'(dec_word), 32'd0);
    chk("R1 reset strobe", 32'(dec_strobe), 32'd0);
    rst_n = 1'b1;

    // R1/R2/R3/R4: limits at reset values, mode 0
    clear_tracks();
    tok[0] = 1; tz[0] = 200;   tp[0] = 0;    trg[0] = 0;
    tok[1] = 1; tz[1] = -199;  tp[1] = -255; trg[1] = 1;
    tok[2] = 1; tz[2] = -2048; tp[2] = 0;    trg[2] = 0;
    tok[3] = 0; tz[3] = 0;     tp[3] = 0;    trg[3] = 0;
    tok[4] = 1; tz[4] = 0;     tp[4] = 256;  trg[4] = 0;
    tok[5] = 1; tz[5] = 0;     tp[5] = -256; trg[5] = 1;
    frame("R2 limits", 12'h03f, 12'hfc0, 0, 0, 0);
    chk("R2 equal fails, R1 defaults", 32'(dec_word), 32'h02);

    clear_tracks();
    tok[0] = 1; tz[0] = 199;   tp[0] = 255;  trg[0] = 0;
    tok[1] = 1; tz[1] = -2047; tp[1] = 0;    trg[1] = 1;
    frame("R4 sixteenth 0", 12'hfff, 12'h000, 0, 0, 0);
    chk("R4 mode 0 word", 32'(dec_word), 32'h01);

    // R3: passing values but valid flag low
    clear_tracks();
    for (int e = 0; e < N; e++) trg[e] = e % 4;
    frame("R3 invalid ignored", 12'hfff, 12'h000, 0, 0, 0);
    chk("R3 word zero", 32'(dec_word), 32'h00);

    // R5/R6/R7 sweeps; mode written mid-frame (R10)
    for (int m = 0; m < 4; m++) begin
      rand_tracks();
      frame("R10 mode write old", 12'h03f, 12'hfc0, 1, 2, m);
      for (int f = 0; f < 14; f++) begin
        rand_tracks();
        if (m == 2 && f == 3)
          frame("R10 zlim write", 12'h0ff, 12'hf00, 1, 0, 100);
        else if (m == 2 && f == 6)
          frame("R10 plim write", 12'h0ff, 12'hf00, 1, 1, 300);
        else if (m == 1 && f == 5)
          frame("R10 ignored select", 12'h0ff, 12'hf00, 1, 3, 5);
        else
          frame(m == 1 ? "R5 mode 1" : m == 2 ? "R6 mode 2" : m == 3 ? "R7 mode 3" : "R4 mode 0",
                12'h0ff, 12'hf00, 0, 0, 0);
        chk("R7 reserved bits", 32'(dec_word[5:4]), 32'd0);
      end
    end

    // R9: incomplete frame held, then completed by the missing engine
    rand_tracks();
    frame("R10 back to mode 1", 12'hfff, 12'h000, 1, 2, 1);
    rand_tracks();
    frame("R5 mode 1 nonzero", 12'hfff, 12'h000, 0, 0, 0);
    clear_tracks();
    tok[0] = 1; tz[0] = 10; tp[0] = 10; trg[0] = 3;
    tok[1] = 1; tz[1] = 10; tp[1] = 10; trg[1] = 0;
    frame("R9 incomplete held", 12'h7ff, 12'h000, 0, 0, 0);
    wait_ph(8);
    chk("R9 still held", 32'(dec_word), 32'(last_word));
    clear_tracks();
    frame("R9 completed later", 12'h800, 12'h000, 0, 0, 0);
    chk("R9 earlier tracks kept", 32'(dec_word), 32'h0f);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule